// File: doc/BRIEF.md
# Trace Pin Configurator and Byte Serializer

This block sits between a trace formatter and the package pins of a debug trace port. A trace enable bit and a two-bit pin mode field decide which pins the port claims. The choices are none, the single serial-wire output, or a clock pin with one, two or four data pins. The data pins the port does not claim are left released for other use.

Two small configuration fields are written through a one-word register write port. The protocol field chooses between parallel (synchronous) trace and serial-wire (asynchronous) trace. The port-size field chooses how many data pins carry each byte. The gated trace clock stays low until the enable bit has been seen high on two consecutive rising edges, and then it follows the system clock. In parallel trace, bytes from the formatter arrive over a ready/valid handshake. Each byte is shifted out least-significant bits first, one beat per clock cycle. Consecutive bytes follow each other with no idle beat in between. Line encoding for serial-wire trace is handled elsewhere; in that protocol this block only takes no bytes.

Top module: `trace_port_serializer`

## Requirements
- R1: While the trace enable input is 0, the clock pin enable, all four data pin enables and the serial-wire enable are 0, whatever the mode field holds.
- R2: With the enable at 1, mode 00 sets only the serial-wire enable. Modes 01, 10 and 11 clear it, set the clock pin enable, and set data pin enables bits [0], [1:0] and [3:0] respectively, with the remaining data enables at 0.
- R3: The trace clock output is 0 from reset and while the enable is low. After the enable is first sampled at 1 on a rising edge, the output stays 0 through the next cycle. From the second rising edge on, it equals the system clock.
- R4: The protocol field is written with the select input at 0 from write data bits [1:0], and its reset value is 01. Bytes are accepted only while it holds 00; the values 01 and 10 keep byte ready at 0.
- R5: The port-size field is written with the select input at 1 from write data bits [3:0], and its reset value is 0x1. The codes 0x2 and 0x8 select two and four data bits per beat. Every other code, 0x1 included, selects one bit per beat.
- R6: An accepted byte is sent least-significant bits first on data outputs [w-1:0], where w is 1, 2 or 4, taking 8/w beats. Data outputs at and above w are 0. The first beat is on the outputs from the edge that accepts the byte, and each later beat appears one edge after the one before it.
- R7: Byte ready is 1 only when the trace clock is running, the protocol is 00, and the shifter is either empty or showing the last beat of its byte. A steady stream of valid bytes therefore leaves no gap between bytes.
- R8: When the shifter is on its last beat and no byte is offered, the data outputs keep their value unchanged, and no partial byte is ever sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trc_io_en_i | input | 1 | Trace pin enable |
| trc_mode_i | input | 2 | Pin mode: 00 serial-wire, 01/10/11 parallel with 1/2/4 data pins |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Write target: 0 protocol field, 1 port-size field |
| cfg_wdata_i | input | 4 | Configuration write data |
| byte_i | input | BYTE_W | Formatter byte |
| byte_valid_i | input | 1 | Byte offered |
| byte_ready_o | output | 1 | Byte taken on this edge when valid |
| trc_clk_o | output | 1 | Gated trace clock |
| trc_clk_oe_o | output | 1 | Trace clock pin enable |
| trc_dat_o | output | 4 | Trace data pins |
| trc_dat_oe_o | output | 4 | Per data pin enable |
| swo_oe_o | output | 1 | Serial-wire output enable |

## Verification
Streams of three back-to-back bytes are sent at each port size: one bit, two bits, four bits, and a code outside the legal set. The byte values are chosen so that bit order, lane placement and masking of unused lanes all show up as distinct nibble sequences. The back-to-back streams separate a design that inserts a bubble between bytes from one that pipelines ready correctly. Idle periods after each stream separate holding the last beat from drifting to a new value. Offering a byte under the reset protocol, under 10, and after trace is disabled separates acceptance that depends on protocol and clock state from unconditional acceptance. Stepping the mode field with the enable both low and high covers every pin-enable pattern.

// File: rtl/trc_pkg.sv
package trc_pkg;

   localparam int unsigned LANES_MAX = 4;

   typedef enum logic [1:0] {
      LANE_X1 = 2'd0,
      LANE_X2 = 2'd1,
      LANE_X4 = 2'd2
   } lane_e;

   typedef enum logic {
      CFG_PROTO = 1'b0,
      CFG_SIZE  = 1'b1
   } cfg_sel_e;

   localparam logic [1:0] PROTO_PARALLEL = 2'b00;
   localparam logic [1:0] PROTO_RESET    = 2'b01;

   localparam logic [3:0] SIZE_ONE  = 4'h1;
   localparam logic [3:0] SIZE_TWO  = 4'h2;
   localparam logic [3:0] SIZE_FOUR = 4'h8;

   function automatic lane_e size_to_lane(input logic [3:0] code);
      case (code)
         SIZE_TWO:  return LANE_X2;
         SIZE_FOUR: return LANE_X4;
         default:   return LANE_X1;
      endcase
   endfunction

   function automatic logic [LANES_MAX-1:0] lane_mask(input lane_e l);
      case (l)
         LANE_X2: return 4'b0011;
         LANE_X4: return 4'b1111;
         default: return 4'b0001;
      endcase
   endfunction

   function automatic int unsigned lane_count(input lane_e l);
      case (l)
         LANE_X2: return 2;
         LANE_X4: return 4;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs
   import trc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       we_i,
   input  logic       sel_i,
   input  logic [3:0] wdata_i,
   output logic       parallel_o,
   output lane_e      lane_o
);

   logic [1:0] proto_q;
   logic [3:0] size_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         proto_q <= PROTO_RESET;
         size_q  <= SIZE_ONE;
      end else if (we_i) begin
         if (sel_i == CFG_SIZE) begin
            size_q <= wdata_i;
         end else begin
            proto_q <= wdata_i[1:0];
         end
      end
   end

   assign parallel_o = (proto_q == PROTO_PARALLEL);
   assign lane_o     = size_to_lane(size_q);

endmodule

// File: rtl/trc_clk_gate.sv
module trc_clk_gate #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic run_o,
   output logic clk_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("trc_clk_gate: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= en_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[STAGES-2:0], en_i};
         end

         // R3
         clk_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(en_i) |=> !run_o);
      end
   endgenerate

   assign run_o = chain_q[STAGES-1];
   assign clk_o = clk_i & run_o;

endmodule

// File: rtl/trc_shifter.sv
module trc_shifter
   import trc_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 adv_i,
   input  logic                 ld_i,
   input  logic [BYTE_W-1:0]    byte_i,
   input  lane_e                lane_i,
   output logic [LANES_MAX-1:0] dat_o,
   output logic                 idle_o
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);

   generate
      if (BYTE_W < LANES_MAX || (BYTE_W % LANES_MAX) != 0) begin : g_bad_width
         $error("trc_shifter: BYTE_W must be a multiple of the widest lane count");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] last_beat(input lane_e l);
      return CNT_W'(BYTE_W / lane_count(l) - 1);
   endfunction

   logic [BYTE_W-1:0]    sh_q;
   logic [CNT_W-1:0]     left_q;
   lane_e                lane_q;
   logic [LANES_MAX-1:0] dat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         left_q <= '0;
         lane_q <= LANE_X1;
         dat_q  <= '0;
      end else if (ld_i) begin
         dat_q  <= byte_i[LANES_MAX-1:0] & lane_mask(lane_i);
         sh_q   <= byte_i >> lane_count(lane_i);
         left_q <= last_beat(lane_i);
         lane_q <= lane_i;
      end else if (adv_i && left_q != '0) begin
         dat_q  <= sh_q[LANES_MAX-1:0] & lane_mask(lane_q);
         sh_q   <= sh_q >> lane_count(lane_q);
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign idle_o = (left_q == '0);
   assign dat_o  = dat_q;

   // R7
   load_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i |-> (left_q == '0));

   // R8
   hold_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (left_q == '0 && !ld_i) |=> $stable(dat_q));

endmodule

// File: rtl/trc_pin_map.sv
module trc_pin_map
   import trc_pkg::*;
(
   input  logic                 io_en_i,
   input  logic [1:0]           mode_i,
   output logic                 clk_oe_o,
   output logic [LANES_MAX-1:0] dat_oe_o,
   output logic                 swo_oe_o
);

   logic       parallel;
   logic [2:0] pins_used;

   assign parallel = io_en_i && (mode_i != 2'b00);
   assign swo_oe_o = io_en_i && (mode_i == 2'b00);
   assign clk_oe_o = parallel;

   always_comb begin
      case (mode_i)
         2'b01:   pins_used = 3'd1;
         2'b10:   pins_used = 3'd2;
         2'b11:   pins_used = 3'd4;
         default: pins_used = 3'd0;
      endcase
   end

   generate
      for (genvar g = 0; g < LANES_MAX; g++) begin : g_pin
         assign dat_oe_o[g] = parallel && (3'(g) < pins_used);
      end
   endgenerate

   always_comb begin
      // R2
      swo_excl_chk: assert ($isunknown({io_en_i, mode_i}) || !(swo_oe_o && clk_oe_o));
   end

endmodule

// File: rtl/trace_port_serializer.sv
module trace_port_serializer
   import trc_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned EN_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              trc_io_en_i,
   input  logic [1:0]        trc_mode_i,
   input  logic              cfg_we_i,
   input  logic              cfg_sel_i,
   input  logic [3:0]        cfg_wdata_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              byte_valid_i,
   output logic              byte_ready_o,
   output logic              trc_clk_o,
   output logic              trc_clk_oe_o,
   output logic [3:0]        trc_dat_o,
   output logic [3:0]        trc_dat_oe_o,
   output logic              swo_oe_o
);

   logic  parallel;
   lane_e lane;
   logic  run;
   logic  idle;
   logic  ld;

   trc_cfg_regs i_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (cfg_we_i),
      .sel_i      (cfg_sel_i),
      .wdata_i    (cfg_wdata_i),
      .parallel_o (parallel),
      .lane_o     (lane)
   );

   trc_clk_gate #(.STAGES(EN_STAGES)) i_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (trc_io_en_i),
      .run_o  (run),
      .clk_o  (trc_clk_o)
   );

   assign byte_ready_o = run && parallel && idle;
   assign ld           = byte_valid_i && byte_ready_o;

   trc_shifter #(.BYTE_W(BYTE_W)) i_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (run),
      .ld_i   (ld),
      .byte_i (byte_i),
      .lane_i (lane),
      .dat_o  (trc_dat_o),
      .idle_o (idle)
   );

   trc_pin_map i_pins (
      .io_en_i  (trc_io_en_i),
      .mode_i   (trc_mode_i),
      .clk_oe_o (trc_clk_oe_o),
      .dat_oe_o (trc_dat_oe_o),
      .swo_oe_o (swo_oe_o)
   );

   // R1
   pins_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trc_io_en_i |-> (trc_dat_oe_o == 4'b0000 && !trc_clk_oe_o && !swo_oe_o));

endmodule

// File: tb/test_trace_port_serializer.sv
module test_trace_port_serializer;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       io_en;
   logic [1:0] mode;
   logic       cfg_we;
   logic       cfg_sel;
   logic [3:0] cfg_wdata;
   logic [7:0] byte_d;
   logic       byte_valid;
   logic       byte_ready;
   logic       trc_clk;
   logic       trc_clk_oe;
   logic [3:0] trc_dat;
   logic [3:0] trc_dat_oe;
   logic       swo_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [3:0] exp_q[$];

   always #2 clk = ~clk;

   trace_port_serializer i_trace_port_serializer (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .trc_io_en_i  (io_en),
      .trc_mode_i   (mode),
      .cfg_we_i     (cfg_we),
      .cfg_sel_i    (cfg_sel),
      .cfg_wdata_i  (cfg_wdata),
      .byte_i       (byte_d),
      .byte_valid_i (byte_valid),
      .byte_ready_o (byte_ready),
      .trc_clk_o    (trc_clk),
      .trc_clk_oe_o (trc_clk_oe),
      .trc_dat_o    (trc_dat),
      .trc_dat_oe_o (trc_dat_oe),
      .swo_oe_o     (swo_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [3:0] data);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input int w);
      bit acc = 0;
      logic [3:0] m;
      m = (w == 4) ? 4'hF : (w == 2) ? 4'h3 : 4'h1;
      for (int i = 0; i < 8 / w; i++) exp_q.push_back(4'((b >> (i * w))) & m);
      byte_d     = b;
      byte_valid = 1'b1;
      while (!acc) begin
         #1 acc = byte_ready;
         @(negedge clk);
      end
   endtask

   task automatic stream3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                          input int w);
      send_byte(a, w);
      send_byte(b, w);
      send_byte(c, w);
      byte_valid = 1'b0;
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   // Scoreboard monitor: a handshake before an edge starts the beat stream after it
   initial begin
      bit hs;
      bit active = 0;
      logic [3:0] e;
      forever begin
         @(negedge clk);
         #1 hs = byte_valid && byte_ready;
         @(posedge clk);
         #1;
         if (hs) active = 1;
         if (active && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            // R6 beat order, lane placement and unused-lane masking
            check("R6", {28'd0, trc_dat}, {28'd0, e});
         end
         if (exp_q.size() == 0) active = 0;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0] held;
      rst_n      = 1'b0;
      io_en      = 1'b0;
      mode       = 2'b11;
      cfg_we     = 1'b0;
      cfg_sel    = 1'b0;
      cfg_wdata  = 4'h0;
      byte_d     = 8'h00;
      byte_valid = 1'b0;

      repeat (2) @(posedge clk);
      #1;
      // Reset state
      check("R3 clock low in reset", {31'd0, trc_clk}, 32'd0);
      check("R1 no pins in reset", {26'd0, trc_clk_oe, swo_oe, trc_dat_oe}, 32'd0);
      check("R7 not ready in reset", {31'd0, byte_ready}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: disabled with a parallel mode
      repeat (3) @(negedge clk);
      for (int m = 0; m < 4; m++) begin
         mode = 2'(m);
         #1;
         check("R1 enable low", {26'd0, trc_clk_oe, swo_oe, trc_dat_oe}, 32'd0);
         @(negedge clk);
      end
      @(posedge clk);
      #1 check("R3 clock low while disabled", {31'd0, trc_clk}, 32'd0);
      @(negedge clk);

      // R3: two-edge delay of the trace clock
      io_en = 1'b1;
      mode  = 2'b00;
      @(posedge clk);
      #1 check("R3 low one edge after enable", {31'd0, trc_clk}, 32'd0);
      @(posedge clk);
      #1 check("R3 follows clock high", {31'd0, trc_clk}, 32'd1);
      @(negedge clk);
      #1 check("R3 follows clock low", {31'd0, trc_clk}, 32'd0);

      // R2: pin patterns
      check("R2 mode 00", {26'd0, trc_clk_oe, swo_oe, trc_dat_oe}, {26'd0, 2'b01, 4'b0000});
      mode = 2'b01;
      #1 check("R2 mode 01", {26'd0, trc_clk_oe, swo_oe, trc_dat_oe}, {26'd0, 2'b10, 4'b0001});
      mode = 2'b10;
      #1 check("R2 mode 10", {26'd0, trc_clk_oe, swo_oe, trc_dat_oe}, {26'd0, 2'b10, 4'b0011});
      mode = 2'b11;
      #1 check("R2 mode 11", {26'd0, trc_clk_oe, swo_oe, trc_dat_oe}, {26'd0, 2'b10, 4'b1111});
      @(negedge clk);

      // R4: reset protocol 01 refuses bytes
      byte_d     = 8'hA5;
      byte_valid = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check("R4 reset protocol refuses", {31'd0, byte_ready}, 32'd0);
      check("R8 nothing sent while refused", {28'd0, trc_dat}, 32'd0);
      @(negedge clk);
      byte_valid = 1'b0;

      cfg_write(1'b0, 4'b0000);
      #1 check("R4 parallel protocol ready", {31'd0, byte_ready}, 32'd1);
      @(negedge clk);

      // R5/R6/R7: one bit per beat (reset size), back-to-back
      stream3(8'hA5, 8'h3C, 8'h0F, 1);
      held = trc_dat;
      repeat (5) @(negedge clk);
      check("R8 hold after stream", {28'd0, trc_dat}, {28'd0, held});
      check("R7 ready when empty", {31'd0, byte_ready}, 32'd1);

      // R5: two bits per beat
      cfg_write(1'b1, 4'h2);
      stream3(8'hE4, 8'h1B, 8'h96, 2);
      held = trc_dat;
      repeat (4) @(negedge clk);
      check("R8 hold two-bit", {28'd0, trc_dat}, {28'd0, held});

      // R5: four bits per beat
      cfg_write(1'b1, 4'h8);
      stream3(8'h5A, 8'hC3, 8'h7E, 4);

      // R5: illegal size code behaves as one bit
      cfg_write(1'b1, 4'h4);
      stream3(8'h81, 8'h6D, 8'hF0, 1);

      // R4: protocol 10 refuses
      cfg_write(1'b0, 4'b0010);
      #1 check("R4 protocol 10 refuses", {31'd0, byte_ready}, 32'd0);
      @(negedge clk);
      cfg_write(1'b0, 4'b0000);

      // R7: disabling trace stops acceptance and the clock
      io_en = 1'b0;
      repeat (3) @(negedge clk);
      #1 check("R7 not ready after disable", {31'd0, byte_ready}, 32'd0);
      @(posedge clk);
      #1 check("R3 clock stopped after disable", {31'd0, trc_clk}, 32'd0);
      check("R1 pins released after disable", {26'd0, trc_clk_oe, swo_oe, trc_dat_oe}, 32'd0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule